// File: doc/BRIEF.md
# Rotate-Right Execution Unit

This unit executes the rotate-right instructions of a 64-bit core. Each cycle it may accept one instruction word together with the two source operand values. It decodes the word and rotates the target operand right by an amount taken from the immediate field or from the source register value. One clock later it presents the destination index, the write data and a write enable.

There are five forms. The word forms rotate the low half of the operand and sign-extend the 32-bit result to 64 bits. The doubleword forms rotate all 64 bits. A rotate is told apart from an ordinary shift by a value of 1 in a field that a shift leaves at zero. That field is the source-register field for the immediate forms and the shift-amount field for the variable forms. Any word that does not match one of the five forms raises an illegal flag for that result, and no write is enabled.

The datapath is two logarithmic barrel rotators, one 32 bits wide and one 64 bits wide, each feeding a single output register.

Top module: `rot_unit`

## Requirements
Instruction fields: primary opcode is bits [31:26] and must be 000000; the source field `s` is [25:21], target [20:16], destination [15:11], immediate amount `sa` is [10:6], and the function code is [5:0].
- R1: Word immediate form (function 000010, `s` = 00001): the result is the low 32 bits of the target operand rotated right by `sa`, then sign-extended.
- R2: Word variable form (function 000110, `sa` = 00001): the amount is bits [4:0] of the source value, and its higher bits are ignored.
- R3: Doubleword immediate form (function 111010, `s` = 00001): the full 64-bit target operand is rotated right by `sa`.
- R4: Doubleword high immediate form (function 111110, `s` = 00001): the full operand is rotated right by `sa` + 32.
- R5: Doubleword variable form (function 010110, `sa` = 00001): the amount is bits [5:0] of the source value, and its higher bits are ignored.
- R6: Every word form writes bits [63:32] as copies of bit 31 of its rotated result, so bits [63:32] of the target operand have no effect.
- R7: An amount of zero returns the operand unchanged: the full value for doubleword forms, and the sign-extended low half for word forms.
- R8: Any other word presented with the valid input asserted gives illegal = 1, write enable = 0 and write data = 0. This covers a nonzero opcode, a marker field that is not 00001, and an unknown function code.
- R9: Results appear exactly one cycle after a valid input. In a cycle after no valid input, the valid output, the write enable and the illegal flag are all 0, and the write data holds its last value.
- R10: For every accepted word, the destination index output equals bits [15:11] of that word.
- R11: During reset, and until the first valid input, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | An instruction word is presented this cycle |
| instr | input | 32 | Instruction word |
| rs_val | input | 64 | Source register value (amount for variable forms) |
| rt_val | input | 64 | Target register value to rotate |
| out_valid | output | 1 | A result for the previous cycle's word is present |
| wr_en | output | 1 | Write the destination register |
| illegal | output | 1 | The previous word was not a rotate form |
| rd_idx | output | 5 | Destination register index |
| rd_data | output | 64 | Destination write data |

## Verification
The assertions check the following on every cycle: the one-cycle handshake; that write enable and the illegal flag never both rise; zero write data on an illegal result; illegal on a nonzero opcode; sign extension on word forms; pass-through at a zero doubleword amount; and the destination index. Rotation by each particular amount, masking of the source value's upper bits, and the plus-32 offset can only be shown by the bench. The bench sweeps every amount of every form over several operand patterns and compares the result against a shift-and-OR model.

// File: rtl/rot_pkg.sv
package rot_pkg;
    localparam int XLEN  = 64;
    localparam int HALF  = XLEN / 2;
    localparam int SHW   = $clog2(XLEN);
    localparam int IW    = 32;
    localparam int REGW  = 5;

    localparam logic [5:0]      FN_W_IMM   = 6'b000010;
    localparam logic [5:0]      FN_W_VAR   = 6'b000110;
    localparam logic [5:0]      FN_D_IMM   = 6'b111010;
    localparam logic [5:0]      FN_D_HI    = 6'b111110;
    localparam logic [5:0]      FN_D_VAR   = 6'b010110;
    localparam logic [REGW-1:0] ROT_MARK   = 5'b00001;

    typedef enum logic [2:0] {
        RF_NONE,
        RF_W_IMM,
        RF_W_VAR,
        RF_D_IMM,
        RF_D_HI,
        RF_D_VAR
    } rot_form_e;

    typedef struct packed {
        logic            valid;
        logic            wr_en;
        logic            illegal;
        logic [REGW-1:0] rd_idx;
        logic [XLEN-1:0] data;
    } rot_out_t;
endpackage

// File: rtl/rot_decode.sv
module rot_decode
    import rot_pkg::*;
(
    input  logic [IW-1:0]   instr,
    input  logic [XLEN-1:0] rs_val,
    output rot_form_e       form,
    output logic            is_word,
    output logic [SHW-1:0]  amount
);
    logic [5:0]      op_f;
    logic [REGW-1:0] src_f;
    logic [REGW-1:0] sa_f;
    logic [5:0]      fn_f;

    assign op_f  = instr[31:26];
    assign src_f = instr[25:21];
    assign sa_f  = instr[10:6];
    assign fn_f  = instr[5:0];

    always_comb begin
        form = RF_NONE;
        if (op_f == 6'b0) begin
            case (fn_f)
                FN_W_IMM: if (src_f == ROT_MARK) form = RF_W_IMM;
                FN_W_VAR: if (sa_f  == ROT_MARK) form = RF_W_VAR;
                FN_D_IMM: if (src_f == ROT_MARK) form = RF_D_IMM;
                FN_D_HI:  if (src_f == ROT_MARK) form = RF_D_HI;
                FN_D_VAR: if (sa_f  == ROT_MARK) form = RF_D_VAR;
                default:  form = RF_NONE;
            endcase
        end
    end

    always_comb begin
        amount  = '0;
        is_word = 1'b0;
        case (form)
            RF_W_IMM: begin amount = {1'b0, sa_f};              is_word = 1'b1; end
            RF_W_VAR: begin amount = {1'b0, rs_val[SHW-2:0]};   is_word = 1'b1; end
            RF_D_IMM: amount = {1'b0, sa_f};
            RF_D_HI:  amount = {1'b1, sa_f};
            RF_D_VAR: amount = rs_val[SHW-1:0];
            default:  amount = '0;
        endcase
    end
endmodule

// File: rtl/rot_barrel.sv
module rot_barrel #(
    parameter int W = 64,
    localparam int LG = $clog2(W)
) (
    input  logic [W-1:0]  din,
    input  logic [LG-1:0] amt,
    output logic [W-1:0]  dout
);
    logic [W-1:0] stage [0:LG];

    assign stage[0] = din;

    for (genvar k = 0; k < LG; k++) begin : g_stage
        localparam int STEP = 1 << k;
        assign stage[k+1] = amt[k]
            ? {stage[k][STEP-1:0], stage[k][W-1:STEP]}
            : stage[k];
    end

    assign dout = stage[LG];
endmodule

// File: rtl/rot_unit.sv
module rot_unit
    import rot_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [IW-1:0]   instr,
    input  logic [XLEN-1:0] rs_val,
    input  logic [XLEN-1:0] rt_val,
    output logic            out_valid,
    output logic            wr_en,
    output logic            illegal,
    output logic [REGW-1:0] rd_idx,
    output logic [XLEN-1:0] rd_data
);
    rot_form_e      form;
    logic           is_word;
    logic [SHW-1:0] amount;
    logic [HALF-1:0] word_rot;
    logic [XLEN-1:0] dbl_rot;
    rot_out_t       st_d;
    rot_out_t       st_q;

    rot_decode i_dec (
        .instr   (instr),
        .rs_val  (rs_val),
        .form    (form),
        .is_word (is_word),
        .amount  (amount)
    );

    rot_barrel #(.W(HALF)) i_rot_w (
        .din  (rt_val[HALF-1:0]),
        .amt  (amount[SHW-2:0]),
        .dout (word_rot)
    );

    rot_barrel #(.W(XLEN)) i_rot_d (
        .din  (rt_val),
        .amt  (amount),
        .dout (dbl_rot)
    );

    always_comb begin
        st_d         = st_q;
        st_d.valid   = 1'b0;
        st_d.wr_en   = 1'b0;
        st_d.illegal = 1'b0;
        if (in_valid) begin
            st_d.valid  = 1'b1;
            st_d.rd_idx = instr[15:11];
            if (form == RF_NONE) begin
                st_d.illegal = 1'b1;
                st_d.data    = '0;
            end else begin
                st_d.wr_en = 1'b1;
                st_d.data  = is_word ? {{HALF{word_rot[HALF-1]}}, word_rot}
                                     : dbl_rot;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.valid;
    assign wr_en     = st_q.wr_en;
    assign illegal   = st_q.illegal;
    assign rd_idx    = st_q.rd_idx;
    assign rd_data   = st_q.data;
endmodule

// File: rtl/rot_unit_chk.sv
module rot_unit_chk
    import rot_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            in_valid,
    input logic [IW-1:0]   instr,
    input logic [XLEN-1:0] rt_val,
    input logic            out_valid,
    input logic            wr_en,
    input logic            illegal,
    input logic [REGW-1:0] rd_idx,
    input logic [XLEN-1:0] rd_data
);
    p_valid_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && !wr_en && !illegal));
    p_excl_flags_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_en, illegal}));
    p_illegal_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (rd_data == '0));
    p_bad_opcode_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && instr[31:26] != 6'b0) |=> (illegal && !wr_en));
    p_word_sext_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && instr[31:21] == 11'b00000000001 && instr[5:0] == FN_W_IMM)
        |=> (rd_data[XLEN-1:HALF] == {HALF{rd_data[HALF-1]}}));
    p_zero_amt_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && instr[31:21] == 11'b00000000001 && instr[10:6] == 5'b0
         && instr[5:0] == FN_D_IMM)
        |=> (wr_en && rd_data == $past(rt_val)));
    p_dest_idx_r10: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (rd_idx == $past(instr[15:11])));
endmodule

bind rot_unit rot_unit_chk i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .instr     (instr),
    .rt_val    (rt_val),
    .out_valid (out_valid),
    .wr_en     (wr_en),
    .illegal   (illegal),
    .rd_idx    (rd_idx),
    .rd_data   (rd_data)
);

// File: tb/test_rot_unit.sv
module test_rot_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] instr = '0;
    logic [63:0] rs_val = '0;
    logic [63:0] rt_val = '0;
    logic        out_valid, wr_en, illegal;
    logic [4:0]  rd_idx;
    logic [63:0] rd_data;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    rot_unit i_rot_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
        .rs_val(rs_val), .rt_val(rt_val), .out_valid(out_valid),
        .wr_en(wr_en), .illegal(illegal), .rd_idx(rd_idx), .rd_data(rd_data)
    );

    function automatic logic [31:0] mk(input logic [5:0] op, input logic [4:0] s,
        input logic [4:0] t, input logic [4:0] d, input logic [4:0] sa,
        input logic [5:0] fn);
        return {op, s, t, d, sa, fn};
    endfunction

    function automatic logic [63:0] ref_d(input logic [63:0] x, input int s);
        return (s == 0) ? x : ((x >> s) | (x << (64 - s)));
    endfunction

    function automatic logic [63:0] ref_w(input logic [63:0] x, input int s);
        logic [31:0] lo;
        logic [31:0] r;
        lo = x[31:0];
        r = (s == 0) ? lo : ((lo >> s) | (lo << (32 - s)));
        return {{32{r[31]}}, r};
    endfunction

    task automatic apply(input string req, input logic [31:0] w,
        input logic [63:0] rt, input logic [63:0] rs,
        input logic exp_wr, input logic [63:0] exp_data);
        in_valid = 1'b1; instr = w; rt_val = rt; rs_val = rs;
        @(negedge clk);
        in_valid = 1'b0;
        n_vec++;
        if (out_valid !== 1'b1 || wr_en !== exp_wr || illegal !== !exp_wr
            || rd_idx !== w[15:11] || rd_data !== exp_data) begin
            n_bad++;
            $display("FAIL %s instr=%h: v=%b we=%b il=%b idx=%0d data=%h expected v=1 we=%b il=%b idx=%0d data=%h",
                req, w, out_valid, wr_en, illegal, rd_idx, rd_data,
                exp_wr, !exp_wr, w[15:11], exp_data);
        end
    endtask

    task automatic idle_check(input logic [63:0] held);
        in_valid = 1'b0;
        @(negedge clk);
        n_vec++;
        if (out_valid !== 1'b0 || wr_en !== 1'b0 || illegal !== 1'b0 || rd_data !== held) begin
            n_bad++;
            $display("FAIL R9 idle: v=%b we=%b il=%b data=%h expected 0 0 0 data=%h",
                out_valid, wr_en, illegal, rd_data, held);
        end
    endtask

    logic [63:0] pats [3] = '{64'h8000_0000_0000_0001,
                              64'h0123_4567_89AB_CDEF,
                              64'hFFFF_0000_7FFF_FFFE};

    initial begin
        repeat (3) @(negedge clk);
        n_vec++;
        if (out_valid !== 0 || wr_en !== 0 || illegal !== 0 || rd_idx !== 0 || rd_data !== 0) begin
            n_bad++;
            $display("FAIL R11 reset: v=%b we=%b il=%b idx=%0d data=%h expected all 0",
                out_valid, wr_en, illegal, rd_idx, rd_data);
        end
        rst_n = 1'b1;
        @(negedge clk);
        n_vec++;
        if (out_valid !== 0 || rd_data !== 0) begin
            n_bad++;
            $display("FAIL R11 post-reset idle: v=%b data=%h expected 0 0", out_valid, rd_data);
        end

        for (int p = 0; p < 3; p++) begin
            for (int s = 0; s < 32; s++) begin
                // R1 / R6 / R7: word immediate
                apply("R1", mk(6'd0, 5'd1, 5'd7, 5'(s), 5'(s), 6'b000010),
                      pats[p], 64'h0, 1'b1, ref_w(pats[p], s));
                // R2: word variable, upper source bits ignored
                apply("R2", mk(6'd0, 5'd9, 5'd7, 5'(31 - s), 5'd1, 6'b000110),
                      pats[p], 64'hA5A5_A5A5_A5A5_A5E0 | 64'(s), 1'b1, ref_w(pats[p], s));
                // R3: doubleword immediate
                apply("R3", mk(6'd0, 5'd1, 5'd3, 5'd4, 5'(s), 6'b111010),
                      pats[p], 64'h0, 1'b1, ref_d(pats[p], s));
                // R4: doubleword immediate plus 32
                apply("R4", mk(6'd0, 5'd1, 5'd3, 5'd5, 5'(s), 6'b111110),
                      pats[p], 64'h0, 1'b1, ref_d(pats[p], s + 32));
            end
            for (int s = 0; s < 64; s++) begin
                // R5: doubleword variable, upper source bits ignored
                apply("R5", mk(6'd0, 5'd2, 5'd3, 5'd6, 5'd1, 6'b010110),
                      pats[p], 64'h5A5A_5A5A_5A5A_5AC0 | 64'(s), 1'b1, ref_d(pats[p], s));
            end
        end

        // R6: upper half of target has no effect on word forms
        apply("R6", mk(6'd0, 5'd1, 5'd1, 5'd1, 5'd4, 6'b000010),
              64'hFFFF_FFFF_0000_0010, 64'h0, 1'b1, 64'h0000_0000_0000_0001);
        apply("R6", mk(6'd0, 5'd1, 5'd1, 5'd1, 5'd4, 6'b000010),
              64'h0000_0000_0000_0008, 64'h0, 1'b1, 64'hFFFF_FFFF_8000_0000);
        // R7: zero amount pass-through
        apply("R7", mk(6'd0, 5'd1, 5'd1, 5'd2, 5'd0, 6'b111010),
              64'hDEAD_BEEF_0BAD_F00D, 64'h0, 1'b1, 64'hDEAD_BEEF_0BAD_F00D);
        apply("R7", mk(6'd0, 5'd3, 5'd1, 5'd2, 5'd1, 6'b000110),
              64'h1234_5678_8BAD_F00D, 64'hFFFF_FFFF_FFFF_FFE0, 1'b1,
              64'hFFFF_FFFF_8BAD_F00D);
        idle_check(64'hFFFF_FFFF_8BAD_F00D);

        // R8: non-rotate encodings
        apply("R8", mk(6'd1, 5'd1, 5'd1, 5'd3, 5'd2, 6'b000010), 64'hF, 64'h0, 1'b0, 64'h0);
        apply("R8", mk(6'd0, 5'd0, 5'd1, 5'd3, 5'd2, 6'b000010), 64'hF, 64'h0, 1'b0, 64'h0);
        apply("R8", mk(6'd0, 5'd1, 5'd1, 5'd3, 5'd0, 6'b000110), 64'hF, 64'h1, 1'b0, 64'h0);
        apply("R8", mk(6'd0, 5'd2, 5'd1, 5'd3, 5'd2, 6'b111010), 64'hF, 64'h0, 1'b0, 64'h0);
        apply("R8", mk(6'd0, 5'd1, 5'd1, 5'd3, 5'd3, 6'b010110), 64'hF, 64'h1, 1'b0, 64'h0);
        apply("R8", mk(6'd0, 5'd1, 5'd1, 5'd3, 5'd1, 6'b111111), 64'hF, 64'h1, 1'b0, 64'h0);
        apply("R8", mk(6'd0, 5'd1, 5'd1, 5'd3, 5'd1, 6'b000011), 64'hF, 64'h1, 1'b0, 64'h0);
        // R9: idle after a result; R10 checked on every applied word
        apply("R10", mk(6'd0, 5'd1, 5'd1, 5'd31, 5'd8, 6'b111010),
              64'h0000_0000_0000_00FF, 64'h0, 1'b1, 64'hFF00_0000_0000_0000);
        idle_check(64'hFF00_0000_0000_0000);
        idle_check(64'hFF00_0000_0000_0000);

        if (!done) begin
            done = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_bad++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule